// File: doc/BRIEF.md
# Radix-5 Residue Converter

This block turns an unsigned binary word into its residue modulo 125, expressed as three binary-coded base-5 digits. It is meant for the input side of a residue-arithmetic datapath: binary samples go in, and the matching residue channel operands come out one clock later.

The conversion uses no division. Each input bit j stands for a fixed weight, which is 2^j reduced modulo 125 and split ahead of time into base-5 digits. Every digit column is a chain of small gated adders. Each adder adds up to two fixed constants, each one enabled by a single bit, to the running digit that comes down the chain. The carries a column produces become enable bits for the next column up, with constant one or two. The most significant column adds its terms modulo 5 and produces no carry, so no reduction stage follows the array. The input width, the radix and the digit count are parameters. The default is 8 bits, radix 5 and 3 digits. The output is registered.

Top module: `b2r5_conv`

## Requirements
- R1: One clock after a non-reset cycle, `res_out` holds the value of `bin_in` from that cycle, taken modulo 125.
- R2: `res_out` carries three 3-bit digit fields: bits [2:0] hold digit 0 (weight 1), bits [5:3] hold digit 1 (weight 5) and bits [8:6] hold digit 2 (weight 25). The value is d2*25 + d1*5 + d0. For example, input 67 gives fields 2, 3, 2 (high to low).
- R3: Every digit field on `res_out` lies in the range 0 to 4.
- R4: A synchronous active-high `rst` sets `res_out` to all zeros on the next clock edge. `bin_in` has no effect while `rst` is high.
- R5: Inputs of 125 or more wrap around: 125 gives 0, 128 gives 3, 250 gives 0 and 255 gives 5.
- R6: Carries out of the most significant digit are discarded. The largest result is 124, shown as three digits of 4, for both input 124 and input 249.
- R7: When inputs change on every clock, each result depends only on its own input. No state carries over from one conversion to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bin_in | input | IN_W (8) | Unsigned binary operand |
| res_out | output | NDIG*3 (9) | Registered residue, three base-5 digits, digit 0 in the lowest bits |

## Verification
The assertions assume that `bin_in` holds a known, steady value at every clock edge outside reset. They also assume that `rst` stays high through the first clock edge, so that the output register starts from a defined value. The bench changes `bin_in` only on falling edges. It holds reset high across the first two edges and again for one mid-stream pulse. Every input pattern it drives, whether an exhaustive sweep, seeded random values or back-to-back streaming, stays within the 8-bit unsigned range that the converter accepts.

// File: rtl/b2r_pkg.sv
package b2r_pkg;

  // Returns 2^j reduced modulo m.
  function automatic int pow2_mod(input int j, input int m);
    int v;
    v = 1 % m;
    for (int i = 0; i < j; i++) v = (v * 2) % m;
    return v;
  endfunction

  // Returns base-r digit k of v.
  function automatic int digit_at(input int v, input int k, input int r);
    int q;
    q = v;
    for (int i = 0; i < k; i++) q = q / r;
    return q % r;
  endfunction

  // Number of gated terms entering column k: the w data bits plus two carry
  // bits from every adder of the column below.
  function automatic int col_terms(input int k, input int w);
    int t;
    t = w;
    for (int i = 1; i <= k; i++) t = w + 2 * ((t + 1) / 2);
    return t;
  endfunction

  // Each adder takes two gated terms.
  function automatic int col_adders(input int k, input int w);
    return (col_terms(k, w) + 1) / 2;
  endfunction

  // Start of column k's carries in the shared carry bus.
  function automatic int carry_off(input int k, input int w);
    int o;
    o = 0;
    for (int i = 0; i < k; i++) o = o + 2 * col_adders(i, w);
    return o;
  endfunction

endpackage

// File: rtl/rr_sadd.sv
// Gated digit adder with carry. Adds constant A when a_en is high and
// constant B when b_en is high to an incoming digit. The carry is 0 to 2
// (RADIX >= 3).
module rr_sadd #(
  parameter int RADIX = 5,
  parameter int DW    = 3
) (
  input  logic [DW-1:0] d_in,
  input  logic          a_en,
  input  logic [DW-1:0] a_cst,
  input  logic          b_en,
  input  logic [DW-1:0] b_cst,
  output logic [DW-1:0] s_out,
  output logic [1:0]    c_out
);
  localparam int SW = $clog2(3 * (RADIX - 1) + 1);
  localparam logic [SW-1:0] RAD_ONE = SW'(RADIX);
  localparam logic [SW-1:0] RAD_TWO = SW'(2 * RADIX);

  logic [SW-1:0] tot;
  logic [SW-1:0] sub;

  always_comb begin
    tot = SW'(d_in) + (a_en ? SW'(a_cst) : '0) + (b_en ? SW'(b_cst) : '0);
    if (tot >= RAD_TWO) begin
      c_out = 2'd2;
      sub   = RAD_TWO;
    end else if (tot >= RAD_ONE) begin
      c_out = 2'd1;
      sub   = RAD_ONE;
    end else begin
      c_out = 2'd0;
      sub   = '0;
    end
    s_out = DW'(tot - sub);
  end

  // R3
  always_comb begin
    sadd_digit_chk: assert (int'(s_out) < RADIX);
  end
endmodule

// File: rtl/rr_sadd_nc.sv
// Gated digit adder for the top column. Its carry would only have weight
// RADIX^NDIG, so the adder drops it and keeps the sum modulo RADIX.
module rr_sadd_nc #(
  parameter int RADIX = 5,
  parameter int DW    = 3
) (
  input  logic [DW-1:0] d_in,
  input  logic          a_en,
  input  logic [DW-1:0] a_cst,
  input  logic          b_en,
  input  logic [DW-1:0] b_cst,
  output logic [DW-1:0] s_out
);
  localparam int SW = $clog2(3 * (RADIX - 1) + 1);
  localparam logic [SW-1:0] RAD_ONE = SW'(RADIX);

  logic [SW-1:0] tot;

  always_comb begin
    tot   = SW'(d_in) + (a_en ? SW'(a_cst) : '0) + (b_en ? SW'(b_cst) : '0);
    s_out = DW'(tot % RAD_ONE);
  end

  // R6
  always_comb begin
    sadd_nc_digit_chk: assert (int'(s_out) < RADIX);
  end
endmodule

// File: rtl/rr_column.sv
// One digit column that passes carries upward. A chain of gated adders
// takes the terms two at a time.
module rr_column #(
  parameter int RADIX = 5,
  parameter int DW    = 3,
  parameter int NT    = 8
) (
  input  logic [NT-1:0]      en,
  input  logic [NT*DW-1:0]   cst,
  output logic [DW-1:0]      sum_out,
  output logic [NA2-1:0]     cy_out
);
  localparam int NA  = (NT + 1) / 2;
  localparam int NA2 = 2 * NA;

  logic [NA2-1:0]    en_p;
  logic [NA2*DW-1:0] cst_p;
  logic [DW-1:0]     link [NA+1];

  assign en_p    = NA2'(en);
  assign cst_p   = (NA2*DW)'(cst);
  assign link[0] = '0;

  for (genvar i = 0; i < NA; i++) begin : g_stage
    rr_sadd #(.RADIX(RADIX), .DW(DW)) u_add (
      .d_in  (link[i]),
      .a_en  (en_p[2*i]),
      .a_cst (cst_p[(2*i)*DW +: DW]),
      .b_en  (en_p[2*i+1]),
      .b_cst (cst_p[(2*i+1)*DW +: DW]),
      .s_out (link[i+1]),
      .c_out (cy_out[2*i +: 2])
    );
  end

  assign sum_out = link[NA];
endmodule

// File: rtl/rr_column_top.sv
// The most significant column. It has the same chain as the other columns
// but produces no carries.
module rr_column_top #(
  parameter int RADIX = 5,
  parameter int DW    = 3,
  parameter int NT    = 8
) (
  input  logic [NT-1:0]      en,
  input  logic [NT*DW-1:0]   cst,
  output logic [DW-1:0]      sum_out
);
  localparam int NA  = (NT + 1) / 2;
  localparam int NA2 = 2 * NA;

  logic [NA2-1:0]    en_p;
  logic [NA2*DW-1:0] cst_p;
  logic [DW-1:0]     link [NA+1];

  assign en_p    = NA2'(en);
  assign cst_p   = (NA2*DW)'(cst);
  assign link[0] = '0;

  for (genvar i = 0; i < NA; i++) begin : g_stage
    rr_sadd_nc #(.RADIX(RADIX), .DW(DW)) u_add (
      .d_in  (link[i]),
      .a_en  (en_p[2*i]),
      .a_cst (cst_p[(2*i)*DW +: DW]),
      .b_en  (en_p[2*i+1]),
      .b_cst (cst_p[(2*i+1)*DW +: DW]),
      .s_out (link[i+1])
    );
  end

  assign sum_out = link[NA];
endmodule

// File: rtl/b2r5_conv.sv
// Converts binary to a residue modulo RADIX^NDIG in base-RADIX digits.
// Needs RADIX >= 3 and NDIG >= 2.
module b2r5_conv
  import b2r_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int RADIX = 5,
  parameter int NDIG  = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [IN_W-1:0]               bin_in,
  output logic [NDIG*$clog2(RADIX)-1:0] res_out
);
  localparam int DW   = $clog2(RADIX);
  localparam int MODV = RADIX ** NDIG;
  localparam int CB   = carry_off(NDIG - 1, IN_W);

  logic [CB-1:0]        carry_bus;
  logic [NDIG*DW-1:0]   res_next;

  for (genvar k = 0; k < NDIG; k++) begin : g_col
    localparam int NT = col_terms(k, IN_W);
    localparam int NA = (NT + 1) / 2;

    logic [NT-1:0]    en;
    logic [NT*DW-1:0] cst;

    // Data terms: bit t enables digit k of 2^t mod MODV.
    for (genvar t = 0; t < IN_W; t++) begin : g_data
      assign en[t]             = bin_in[t];
      assign cst[t*DW +: DW]   = DW'(digit_at(pow2_mod(t, MODV), k, RADIX));
    end

    // Carry terms from the column below: even bit weighs 1, odd bit weighs 2.
    if (k > 0) begin : g_cin
      localparam int NC = 2 * col_adders(k - 1, IN_W);
      localparam int CO = carry_off(k - 1, IN_W);
      for (genvar c = 0; c < NC; c++) begin : g_c
        assign en[IN_W + c]               = carry_bus[CO + c];
        assign cst[(IN_W + c)*DW +: DW]   = DW'((c % 2 == 0) ? 1 : 2);
      end
    end

    if (k < NDIG - 1) begin : g_low
      rr_column #(.RADIX(RADIX), .DW(DW), .NT(NT)) u_col (
        .en      (en),
        .cst     (cst),
        .sum_out (res_next[k*DW +: DW]),
        .cy_out  (carry_bus[carry_off(k, IN_W) +: 2*NA])
      );
    end else begin : g_top
      rr_column_top #(.RADIX(RADIX), .DW(DW), .NT(NT)) u_col (
        .en      (en),
        .cst     (cst),
        .sum_out (res_next[k*DW +: DW])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst) res_out <= '0;
    else     res_out <= res_next;
  end

  function automatic int dec_res(input logic [NDIG*DW-1:0] v);
    int acc;
    acc = 0;
    for (int k = NDIG - 1; k >= 0; k--) acc = acc * RADIX + int'(v[k*DW +: DW]);
    return acc;
  endfunction

  // R1
  mod_result_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dec_res(res_out) == (int'($past(bin_in)) % MODV)));

  // R4
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (res_out == '0));

  for (genvar k = 0; k < NDIG; k++) begin : g_dchk
    // R3
    digit_legal_chk: assert property (@(posedge clk) disable iff (rst)
      int'(res_out[k*DW +: DW]) < RADIX);
  end
endmodule

// File: tb/sim_b2r5_conv.sv
module sim_b2r5_conv;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bin_in = 8'd0;
  logic [8:0] res_out;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  b2r5_conv #(.IN_W(8), .RADIX(5), .NDIG(3)) u0 (
    .clk(clk), .rst(rst), .bin_in(bin_in), .res_out(res_out)
  );

  always #2 clk = ~clk;

  function automatic int dec(input logic [8:0] r);
    return int'(r[8:6]) * 25 + int'(r[5:3]) * 5 + int'(r[2:0]);
  endfunction

  function automatic int ref_mod(input int x);
    return x % 125;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_digits(input string req);
    for (int k = 0; k < 3; k++) begin
      checks++;
      if (res_out[k*3 +: 3] > 3'd4) begin
        errors++;
        $display("FAIL %s digit %0d actual %0d expected <=4", req, k, res_out[k*3 +: 3]);
      end
    end
  endtask

  // Drives one value, waits for the capturing edge, then samples.
  task automatic apply(input int x, input string req);
    @(negedge clk) bin_in = 8'(x);
    @(negedge clk);
    check(req, dec(res_out), ref_mod(x));
    check_digits("R3");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R1 watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int prev;
    // R4: reset state, input ignored during reset
    bin_in = 8'hFF;
    @(negedge clk);
    @(negedge clk);
    check("R4", int'(res_out), 0);
    rst = 1'b0;

    // R1 R2: exhaustive sweep
    for (int x = 0; x < 256; x++) apply(x, "R1");

    // R2: exact field layout, 67 = 2*25 + 3*5 + 2
    apply(67, "R1");
    check("R2", int'(res_out), int'({3'd2, 3'd3, 3'd2}));

    // R5: wrap-around
    apply(125, "R5");
    apply(128, "R5");
    apply(250, "R5");
    apply(255, "R5");
    check("R5", dec(res_out), 5);

    // R6: top carry dropped, largest result is all fours
    apply(124, "R6");
    check("R6", int'(res_out), int'({3'd4, 3'd4, 3'd4}));
    apply(249, "R6");
    check("R6", int'(res_out), int'({3'd4, 3'd4, 3'd4}));

    // R1: seeded random
    void'($urandom(32'h5EED));
    for (int i = 0; i < 300; i++) apply(int'($urandom_range(255, 0)), "R1");

    // R7: streaming, new input each cycle
    @(negedge clk) begin
      prev = 200;
      bin_in = 8'd200;
    end
    for (int i = 0; i < 200; i++) begin
      int nx;
      nx = int'($urandom_range(255, 0));
      @(negedge clk);
      check("R7", dec(res_out), ref_mod(prev));
      bin_in = 8'(nx);
      prev = nx;
    end

    // R4: mid-stream reset, input ignored while high
    @(negedge clk) begin
      rst = 1'b1;
      bin_in = 8'd77;
    end
    @(negedge clk);
    check("R4", int'(res_out), 0);
    bin_in = 8'd99;
    @(negedge clk);
    check("R4", int'(res_out), 0);
    rst = 1'b0;
    apply(99, "R1");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule